// File: doc/BRIEF.md
# Mappable DMA Request Arbiter

This block sits between a set of hardware DMA request lines and a single transfer engine. Each of the logical channels holds a small programmable record: the number of the request line it listens to, and an enable bit. A channel is pending when it is enabled and the request line it names is high. Several channels may listen to the same line, and any line may feed any channel.

Among the pending channels the arbiter picks one winner and grants it to the transfer engine. It can pick in one of two ways. In fixed-priority mode the lowest channel number wins. In round-robin mode the search starts at a rotating pointer. Only one grant is ever outstanding. The grant stays in place until the engine pulses a done input. After that the arbiter rests for one cycle and then picks again. Software programs the channel records and the scheme through a simple write-only port.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `gnt_valid` is low and `gnt_vec` and `gnt_idx` are zero. Every channel is disabled and maps to source 0, fixed-priority mode is selected, and the rotating pointer is 0. As a result, no request pattern produces a grant until a channel is enabled.
- R2: A write with `cfg_addr` in 0..NUM_CH-1 programs that channel. `cfg_wdata[5:0]` selects the request source and `cfg_wdata[6]` is the enable bit. A channel is pending when it is enabled, its source is below NUM_REQ, and `req[source]` is high. A source of NUM_REQ or above never makes the channel pending.
- R3: Any request line can be mapped to any channel. Two channels mapped to the same line are both pending when that line is high.
- R4: A write to address NUM_CH sets the scheme from `cfg_wdata[0]`: 0 selects fixed priority and 1 selects round-robin. In fixed-priority mode the lowest-numbered pending channel wins.
- R5: In round-robin mode the search starts at the pointer and runs upward, wrapping from NUM_CH-1 back to 0. On every grant, in either mode, the pointer is set to the winner plus one, and it wraps to 0 after NUM_CH-1.
- R6: When no grant is outstanding and at least one channel is pending at a rising clock edge, the grant appears right after that edge. The latency is one register stage.
- R7: Once granted, `gnt_idx` and `gnt_vec` stay fixed until `xfer_done` is seen high at a clock edge. They do not change if the request drops or the channel records are rewritten in the meantime.
- R8: When `xfer_done` is high at an edge while a grant is outstanding, `gnt_valid` is low for the next cycle, and arbitration resumes at the edge after that. `xfer_done` while no grant is outstanding has no effect.
- R9: While `gnt_valid` is high, `gnt_vec` has exactly one bit set, at position `gnt_idx`. While it is low, both are zero.
- R10: Writes to addresses above NUM_CH change neither the channel records nor the scheme.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_REQ (48) | Hardware request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (6) | Configuration address: channel number, or NUM_CH for the scheme |
| cfg_wdata | input | SEL_W+1 (7) | Configuration data: enable bit and source, or scheme bit |
| xfer_done | input | 1 | Transfer engine finished the granted transfer |
| gnt_valid | output | 1 | A grant is outstanding |
| gnt_vec | output | NUM_CH (32) | One-hot grant vector |
| gnt_idx | output | CH_W (5) | Number of the granted channel |

## Verification
The bench targets the round-robin wrap from the top channel back to channel 0. A design that mishandles it would skip channel 1 or grant 31 twice. It also drops the request, and rewrites the mapping, while a grant is outstanding; a design that re-arbitrates early would move `gnt_idx` before done. It sends a done pulse while idle, which a careless design would latch as a spurious transfer end. It programs a mapping to a source at or above 48 and writes to addresses past the scheme register. A decoder with too few bits would then raise a phantom request or flip the scheme, and the bench watches for both. A per-cycle reference model also catches any off-by-one in grant latency, and any missing idle gap after done.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic {
    SCHEME_FIXED = 1'b0,
    SCHEME_ROTATE = 1'b1
  } arb_scheme_e;

  typedef enum logic {
    GS_IDLE = 1'b0,
    GS_BUSY = 1'b1
  } grant_state_e;

endpackage

// File: rtl/dma_map_table.sv
module dma_map_table #(
  parameter int unsigned NUM_REQ = 48,
  parameter int unsigned NUM_CH  = 32,
  parameter int unsigned SEL_W   = 6,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REQ-1:0]  req,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [NUM_CH-1:0]   pend,
  output dma_arb_pkg::arb_scheme_e scheme
);
  import dma_arb_pkg::*;

  localparam int unsigned EXT_W = 1 << SEL_W;

  logic [EXT_W-1:0] req_ext;

  always_comb begin
    req_ext = '0;
    req_ext[NUM_REQ-1:0] = req;
  end

  // Per-channel source selector and enable
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [SEL_W-1:0] src_q, src_d;
    logic             en_q, en_d;
    logic             wr_hit;

    assign wr_hit = cfg_we && (cfg_addr == ADDR_W'(c));

    always_comb begin
      src_d = src_q;
      en_d  = en_q;
      if (wr_hit) begin
        src_d = cfg_wdata[SEL_W-1:0];
        en_d  = cfg_wdata[SEL_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q <= '0;
        en_q  <= 1'b0;
      end else if (wr_hit) begin
        src_q <= src_d;
        en_q  <= en_d;
      end
    end

    // Sources at or above NUM_REQ read a zero from the extended vector
    assign pend[c] = en_q && req_ext[src_q];
  end

  // Scheme register
  logic        scheme_hit;
  arb_scheme_e scheme_q, scheme_d;

  assign scheme_hit = cfg_we && (cfg_addr == ADDR_W'(NUM_CH));

  always_comb begin
    scheme_d = scheme_q;
    if (scheme_hit) scheme_d = arb_scheme_e'(cfg_wdata[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          scheme_q <= SCHEME_FIXED;
    else if (scheme_hit) scheme_q <= scheme_d;
  end

  assign scheme = scheme_q;

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned CH_W   = 5
) (
  input  logic [NUM_CH-1:0]        pend,
  input  dma_arb_pkg::arb_scheme_e scheme,
  input  logic [CH_W-1:0]          ptr,
  output logic                     found,
  output logic [CH_W-1:0]          win_idx
);
  import dma_arb_pkg::*;

  logic [2*NUM_CH-1:0] dbl;
  logic [NUM_CH-1:0]   search;
  logic [CH_W-1:0]     off;
  logic [CH_W-1:0]     base;
  logic [CH_W:0]       sum;

  always_comb begin
    // Rotate so that the pointer's channel sits at bit 0
    dbl    = {pend, pend} >> ptr;
    search = (scheme == SCHEME_ROTATE) ? dbl[NUM_CH-1:0] : pend;
    base   = (scheme == SCHEME_ROTATE) ? ptr : '0;

    found = 1'b0;
    off   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (search[i]) begin
        found = 1'b1;
        off   = CH_W'(i);
      end
    end

    sum = {1'b0, base} + {1'b0, off};
    if (sum >= (CH_W+1)'(NUM_CH)) sum = sum - (CH_W+1)'(NUM_CH);
    win_idx = sum[CH_W-1:0];
  end

endmodule

// File: rtl/dma_grant_ctrl.sv
module dma_grant_ctrl #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              found,
  input  logic [CH_W-1:0]   win_idx,
  input  logic              xfer_done,
  output logic              gnt_valid,
  output logic [CH_W-1:0]   gnt_idx,
  output logic [NUM_CH-1:0] gnt_vec,
  output logic [CH_W-1:0]   ptr
);
  import dma_arb_pkg::*;

  grant_state_e    state_q, state_d;
  logic [CH_W-1:0] idx_q, idx_d;
  logic [CH_W-1:0] ptr_q, ptr_d;
  logic            load_en;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    ptr_d   = ptr_q;
    load_en = 1'b0;
    unique case (state_q)
      GS_IDLE: begin
        if (found) begin
          state_d = GS_BUSY;
          load_en = 1'b1;
          idx_d   = win_idx;
          ptr_d   = (win_idx == CH_W'(NUM_CH - 1)) ? '0 : win_idx + 1'b1;
        end
      end
      GS_BUSY: begin
        if (xfer_done) state_d = GS_IDLE;
      end
      default: state_d = GS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GS_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ptr_q <= '0;
    end else if (load_en) begin
      idx_q <= idx_d;
      ptr_q <= ptr_d;
    end
  end

  assign gnt_valid = (state_q == GS_BUSY);
  assign gnt_idx   = gnt_valid ? idx_q : '0;
  assign ptr       = ptr_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign gnt_vec[c] = gnt_valid && (idx_q == CH_W'(c));
  end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int unsigned NUM_REQ = 48,
  parameter int unsigned NUM_CH  = 32,
  localparam int unsigned SEL_W  = $clog2(NUM_REQ),
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned ADDR_W = $clog2(NUM_CH + 1),
  localparam int unsigned DATA_W = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_REQ-1:0] req,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              xfer_done,
  output logic              gnt_valid,
  output logic [NUM_CH-1:0] gnt_vec,
  output logic [CH_W-1:0]   gnt_idx
);
  import dma_arb_pkg::*;

  logic [NUM_CH-1:0] pend_w;
  arb_scheme_e       scheme_w;
  logic              found_w;
  logic [CH_W-1:0]   win_w;
  logic [CH_W-1:0]   ptr_w;
  logic              rotate_w;

  assign rotate_w = (scheme_w == SCHEME_ROTATE);

  dma_map_table #(
    .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .SEL_W(SEL_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) map_i (
    .clk(clk), .rst_n(rst_n), .req(req),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pend(pend_w), .scheme(scheme_w)
  );

  dma_prio_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) pick_i (
    .pend(pend_w), .scheme(scheme_w), .ptr(ptr_w),
    .found(found_w), .win_idx(win_w)
  );

  dma_grant_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .found(found_w), .win_idx(win_w),
    .xfer_done(xfer_done), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx),
    .gnt_vec(gnt_vec), .ptr(ptr_w)
  );

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned CH_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_done,
  input logic              gnt_valid,
  input logic [NUM_CH-1:0] gnt_vec,
  input logic [CH_W-1:0]   gnt_idx,
  input logic [NUM_CH-1:0] pend,
  input logic              rotate
);

  logic [NUM_CH-1:0] pend_prev;
  logic              rotate_prev;
  logic [NUM_CH-1:0] below_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_prev   <= '0;
      rotate_prev <= 1'b0;
    end else begin
      pend_prev   <= pend;
      rotate_prev <= rotate;
    end
  end

  assign below_mask = (NUM_CH'(1) << gnt_idx) - NUM_CH'(1);

  // R9
  a_r9_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> ($onehot(gnt_vec) && gnt_vec[gnt_idx]));

  // R9
  a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid |-> (gnt_vec == '0 && gnt_idx == '0));

  // R7
  a_r7_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !xfer_done) |=> (gnt_valid && $stable(gnt_idx)));

  // R8
  a_r8_gap_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && xfer_done) |=> !gnt_valid);

  // R6
  a_r6_grant_follows_pend: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid |=> (gnt_valid == (|pend_prev)));

  // R4
  a_r4_fixed_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gnt_valid) && !rotate_prev) |->
      (pend_prev[gnt_idx] && ((pend_prev & below_mask) == '0)));

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .gnt_valid(gnt_valid),
  .gnt_vec(gnt_vec), .gnt_idx(gnt_idx), .pend(pend_w), .rotate(rotate_w)
);

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb_top;

  localparam int NUM_REQ = 48;
  localparam int NUM_CH  = 32;
  localparam int SEL_W   = 6;
  localparam int CH_W    = 5;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 7;

  logic              clk;
  logic              rst_n;
  logic [NUM_REQ-1:0] req;
  logic              cfg_we;
  logic [ADDR_W-1:0] cfg_addr;
  logic [DATA_W-1:0] cfg_wdata;
  logic              xfer_done;
  logic              gnt_valid;
  logic [NUM_CH-1:0] gnt_vec;
  logic [CH_W-1:0]   gnt_idx;

  int    checks = 0;
  int    errors = 0;
  string phase  = "R1";
  bit    finished = 0;

  dma_req_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .xfer_done(xfer_done),
    .gnt_valid(gnt_valid), .gnt_vec(gnt_vec), .gnt_idx(gnt_idx)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference model
  int m_src[NUM_CH];
  bit m_en[NUM_CH];
  bit m_rot;
  bit m_busy;
  int m_idx;
  int m_ptr;

  always @(posedge clk) begin : model
    int w;
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        m_src[c] = 0;
        m_en[c]  = 0;
      end
      m_rot = 0; m_busy = 0; m_idx = 0; m_ptr = 0;
    end else begin
      if (m_busy) begin
        if (xfer_done) m_busy = 0;
      end else begin
        w = -1;
        for (int k = 0; k < NUM_CH; k++) begin
          int c;
          c = m_rot ? (m_ptr + k) % NUM_CH : k;
          if (w < 0 && m_en[c] && m_src[c] < NUM_REQ && req[m_src[c]]) w = c;
        end
        if (w >= 0) begin
          m_busy = 1;
          m_idx  = w;
          m_ptr  = (w + 1) % NUM_CH;
        end
      end
      if (cfg_we) begin
        if (int'(cfg_addr) < NUM_CH) begin
          m_src[cfg_addr] = int'(cfg_wdata[SEL_W-1:0]);
          m_en[cfg_addr]  = cfg_wdata[SEL_W];
        end else if (int'(cfg_addr) == NUM_CH) begin
          m_rot = cfg_wdata[0];
        end
      end
    end
  end

  // Per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      logic [NUM_CH-1:0] exp_vec;
      int exp_idx;
      exp_vec = m_busy ? (NUM_CH'(1) << m_idx) : '0;
      exp_idx = m_busy ? m_idx : 0;
      checks++;
      if (gnt_valid !== m_busy || gnt_vec !== exp_vec || int'(gnt_idx) != exp_idx) begin
        errors++;
        $display("FAIL R6 R9 (%s) per-cycle: valid=%0b idx=%0d vec=%h expected valid=%0b idx=%0d vec=%h",
                 phase, gnt_valid, gnt_idx, gnt_vec, m_busy, exp_idx, exp_vec);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int a, input int d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = a[ADDR_W-1:0];
    cfg_wdata = d[DATA_W-1:0];
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic map_ch(input int ch, input int src, input bit en);
    cfg_write(ch, (int'(en) << SEL_W) | src);
  endtask

  task automatic finish_xfer();
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic wait_grant(input int exp, input string tag);
    for (int i = 0; i < 40; i++) begin
      if (gnt_valid) break;
      @(negedge clk);
    end
    check(gnt_valid && int'(gnt_idx) == exp, tag, "granted channel",
          gnt_valid ? int'(gnt_idx) : -1, exp);
  endtask

  task automatic expect_idle(input int n, input string tag);
    bit seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gnt_valid) seen = 1;
    end
    check(!seen, tag, "grant while none expected", int'(seen), 0);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state and nothing enabled
    phase = "R1";
    check(!gnt_valid && gnt_vec == '0 && gnt_idx == '0, "R1", "reset outputs",
          int'(gnt_valid), 0);
    req = '1;
    expect_idle(6, "R1");
    req = '0;

    // R2 and R6: mapping and one-cycle latency
    phase = "R2";
    map_ch(5, 10, 1);
    req[10] = 1'b1;
    @(negedge clk);
    check(gnt_valid && gnt_idx == 5, "R6", "grant one cycle after request",
          int'(gnt_idx), 5);
    req = '0;
    finish_xfer();
    map_ch(5, 10, 0);
    map_ch(6, 50, 1);
    req = '1;
    expect_idle(5, "R2");
    req = '0;
    map_ch(6, 0, 0);

    // R3: shared line, R7 record rewrite during grant
    phase = "R3";
    map_ch(3, 47, 1);
    map_ch(7, 47, 1);
    req[47] = 1'b1;
    wait_grant(3, "R3");
    map_ch(3, 47, 0);
    check(gnt_valid && gnt_idx == 3, "R7", "held across rewrite", int'(gnt_idx), 3);
    finish_xfer();
    check(!gnt_valid, "R8", "idle gap after done", int'(gnt_valid), 0);
    wait_grant(7, "R3");
    finish_xfer();
    req = '0;
    map_ch(7, 0, 0);

    // R4: fixed priority, R7 hold with request dropped
    phase = "R4";
    map_ch(2, 1, 1);
    map_ch(9, 2, 1);
    map_ch(20, 3, 1);
    req[3:1] = 3'b111;
    wait_grant(2, "R4");
    finish_xfer();
    wait_grant(2, "R4");
    req[1] = 1'b0;
    repeat (3) @(negedge clk);
    check(gnt_valid && gnt_idx == 2, "R7", "held after request drop", int'(gnt_idx), 2);
    finish_xfer();
    wait_grant(9, "R4");
    finish_xfer();
    req = '0;
    map_ch(2, 0, 0);
    map_ch(9, 0, 0);
    map_ch(20, 0, 0);

    // R5: round-robin with wrap
    phase = "R5";
    map_ch(29, 4, 1);
    req[4] = 1'b1;
    wait_grant(29, "R5");
    req[4] = 1'b0;
    finish_xfer();
    map_ch(29, 4, 0);
    map_ch(1, 5, 1);
    map_ch(30, 6, 1);
    map_ch(31, 7, 1);
    cfg_write(NUM_CH, 1);
    req[7:5] = 3'b111;
    wait_grant(30, "R5");
    finish_xfer();
    wait_grant(31, "R5");
    finish_xfer();
    wait_grant(1, "R5");
    finish_xfer();
    wait_grant(30, "R5");
    req = '0;
    finish_xfer();

    // R10: out-of-range writes leave scheme untouched
    phase = "R10";
    cfg_write(40, 0);
    cfg_write(NUM_CH + 1, 0);
    cfg_write(63, 0);
    req[7:5] = 3'b111;
    wait_grant(31, "R10");
    req = '0;
    finish_xfer();
    cfg_write(NUM_CH, 0);
    req[7:5] = 3'b111;
    wait_grant(1, "R4");
    req = '0;
    finish_xfer();

    // R8: done while idle is ignored
    phase = "R8";
    @(negedge clk);
    finish_xfer();
    expect_idle(2, "R8");
    req[6] = 1'b1;
    @(negedge clk);
    check(gnt_valid && gnt_idx == 30, "R8", "grant after idle done", int'(gnt_idx), 30);
    repeat (3) @(negedge clk);
    check(gnt_valid && gnt_idx == 30, "R8", "idle done not stored", int'(gnt_idx), 30);
    req = '0;
    finish_xfer();
    repeat (4) @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule